// File: doc/BRIEF.md
# Compare Timer with Auto-Increment

This block is a memory-mapped timer built around a 64-bit up-counter. The counter advances by one on every cycle in which the tick-enable input is high and the timer is switched on. Software reaches the block through a plain 32-bit register bus, and each 64-bit quantity is split into a low word and a high word.

There are two ways to raise the status flag and the interrupt. The first is an absolute compare point. Software can write that point directly as two words. It can also use a signed relative view that reads as the compare point minus the count, and that sets the compare point to the count plus a signed offset when written. The second is an auto-increment mode. While it is on, it owns the status flag. Each time the count reaches its own compare point, that point moves forward by a programmable reload step. A pending flag then latches and stays set until software clears it through the mode's control register.

The count resets to a value set by a parameter, which defaults to zero. A frequency register is stored for software and has no effect on the timer.

Top module: `tct_timer`

## Requirements
- R1: After reset with default parameters, the control register, both count words and the relative view read 0, and `irq_out` is 0.
- R2: The count increases by exactly one on each cycle in which `tick_in` is 1 and control bit 0 (enable) is 1. On every other cycle it holds its value.
- R3: The control register at 0x2C holds enable in bit 0 and interrupt mask in bit 1, and both can be read and written. Bit 2 is the status flag and is read-only, so writing it has no effect. The flag is 0 whenever enable is 0. With enable set and the flag set, the register reads 5.
- R4: Reading the relative view at 0x28 returns the low 32 bits of (compare − count). Writing value v there sets compare = count + v, with v sign-extended to 64 bits. Compare low and high are at 0x20 and 0x24.
- R5: While auto-increment is off, the status flag equals enable AND (count ≥ compare), where the comparison is unsigned over 64 bits.
- R6: Writing the auto-increment control register at 0x4C with bit 0 = 1 while the mode is off turns the mode on. The same write loads the auto-increment point (read at 0x40 and 0x44) with count + reload and clears the pending flag. The reload step is a 32-bit value at 0x48. Rewriting bit 0 = 1 while the mode is already on does not reload the point.
- R7: While auto-increment is on, the status flag equals enable AND pending. When count ≥ point, pending is set and the point advances by the reload step on the next clock.
- R8: A write to 0x4C with bit 1 = 0 clears pending, and a write with bit 1 = 1 leaves it unchanged. If a match happens in the same cycle, the match wins. Reading 0x4C returns the mode in bit 0 and pending in bit 1.
- R9: `irq_out` is registered and equals, one cycle later, status AND NOT mask.
- R10: The frequency register at 0x10 reads back the last value written to it and does not change the count, the status flag or the interrupt.
- R11: The count and the auto-increment point are true 64-bit values. A carry out of the low word appears in the high word.
- R12: A read issued on `bus_rd` shows its data on `bus_rdata` after the next clock edge, and `bus_rdata` holds that value until the next read. Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Count-advance enable for this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a carry across the 32-bit word boundary, for both the count and the auto-increment point. Reaching it by ticking from zero would take billions of cycles. A second instance is therefore built with its count reset just below a word boundary, and an auto-increment sequence is run across that boundary. A further hard case is the reload chain staying in step with the count over many matches. Random stimulus covers this by interleaving tick bursts with reload changes, clears, re-enables and mask toggles, and comparing every readback against a bench model.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 2 * WORD_W;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  // byte offsets of the register map
  localparam logic [7:0] OFS_CNT_LO = 8'h00;
  localparam logic [7:0] OFS_CNT_HI = 8'h04;
  localparam logic [7:0] OFS_FREQ   = 8'h10;
  localparam logic [7:0] OFS_CMP_LO = 8'h20;
  localparam logic [7:0] OFS_CMP_HI = 8'h24;
  localparam logic [7:0] OFS_REL    = 8'h28;
  localparam logic [7:0] OFS_CTRL   = 8'h2C;
  localparam logic [7:0] OFS_AIP_LO = 8'h40;
  localparam logic [7:0] OFS_AIP_HI = 8'h44;
  localparam logic [7:0] OFS_STEP   = 8'h48;
  localparam logic [7:0] OFS_AICTL  = 8'h4C;

  typedef struct packed {
    logic freq;
    logic cmp_lo;
    logic cmp_hi;
    logic rel;
    logic ctrl;
    logic step;
    logic aictl;
  } wr_sel_t;
endpackage

// File: rtl/tct_counter.sv
module tct_counter
  import tct_pkg::*;
#(
  parameter cnt_t RESET_VAL = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output cnt_t count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= RESET_VAL;
    else if (advance) count <= count + CNT_W'(1);
  end

  // R2: count moves only when advanced, by one
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(count));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    advance |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/tct_abs_cmp.sv
module tct_abs_cmp
  import tct_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cnt_t  count,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  logic  wr_rel,
  input  word_t wdata,
  output cnt_t  cmp,
  output word_t rel_view,
  output logic  reached
);
  cnt_t diff;
  cnt_t rel_target;

  always_comb begin
    diff       = cmp - count;
    rel_view   = diff[WORD_W-1:0];
    rel_target = count + {{WORD_W{wdata[WORD_W-1]}}, wdata};
    reached    = (count >= cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (wr_rel) begin
      cmp <= rel_target;
    end else begin
      if (wr_lo) cmp[WORD_W-1:0]     <= wdata;
      if (wr_hi) cmp[CNT_W-1:WORD_W] <= wdata;
    end
  end

  // R4: a relative write lands at count plus the signed offset
  assert_rel_write_R4: assert property (@(posedge clk) disable iff (rst)
    wr_rel |=> cmp == $past(count) + {{WORD_W{$past(wdata[WORD_W-1])}}, $past(wdata)});
  // R4: compare is untouched without a compare write
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_lo || wr_hi || wr_rel) |=> $stable(cmp));
endmodule

// File: rtl/tct_autoinc.sv
module tct_autoinc
  import tct_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  cnt_t  count,
  input  logic  wr_ctl,
  input  logic  wr_step,
  input  word_t wdata,
  output logic  mode_on,
  output logic  pending,
  output cnt_t  point,
  output word_t step
);
  cnt_t next_point;
  cnt_t load_point;
  logic turn_on;
  logic match;

  always_comb begin
    next_point = point + {{WORD_W{1'b0}}, step};
    load_point = count + {{WORD_W{1'b0}}, step};
    turn_on    = wr_ctl && wdata[0] && !mode_on;
    match      = mode_on && (count >= point);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_on <= 1'b0;
      pending <= 1'b0;
      point   <= '0;
      step    <= '0;
    end else begin
      if (wr_step) step <= wdata;
      if (wr_ctl) mode_on <= wdata[0];
      if (turn_on) begin
        point   <= load_point;
        pending <= 1'b0;
      end else if (match) begin
        point   <= next_point;
        pending <= 1'b1;
      end else if (wr_ctl && !wdata[1]) begin
        pending <= 1'b0;
      end
    end
  end

  // R6: switching the mode on loads count plus step and clears pending
  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    turn_on |=> (point == $past(count) + {{WORD_W{1'b0}}, $past(step)}) && !pending);
  // R7: a match advances the point and latches pending
  assert_match_R7: assert property (@(posedge clk) disable iff (rst)
    (match && !turn_on) |=> pending && (point == $past(point) + {{WORD_W{1'b0}}, $past(step)}));
  // R8: pending only rises through a match
  assert_pend_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(match));
endmodule

// File: rtl/tct_timer.sv
module tct_timer
  import tct_pkg::*;
#(
  parameter int   ADDR_W    = 8,
  parameter cnt_t CNT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  wr_sel_t wsel;
  logic    en_q;
  logic    mask_q;
  word_t   freq_q;
  logic    status;
  logic    reached;
  logic    mode_on;
  logic    pending;
  cnt_t    count;
  cnt_t    cmp;
  cnt_t    point;
  word_t   rel_view;
  word_t   step;
  word_t   rd_mux;

  always_comb begin
    wsel        = '0;
    wsel.freq   = bus_wr && (bus_addr == ADDR_W'(OFS_FREQ));
    wsel.cmp_lo = bus_wr && (bus_addr == ADDR_W'(OFS_CMP_LO));
    wsel.cmp_hi = bus_wr && (bus_addr == ADDR_W'(OFS_CMP_HI));
    wsel.rel    = bus_wr && (bus_addr == ADDR_W'(OFS_REL));
    wsel.ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wsel.step   = bus_wr && (bus_addr == ADDR_W'(OFS_STEP));
    wsel.aictl  = bus_wr && (bus_addr == ADDR_W'(OFS_AICTL));
  end

  tct_counter #(.RESET_VAL(CNT_RESET)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .advance (tick_in && en_q),
    .count   (count)
  );

  tct_abs_cmp u_abs (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .wr_lo    (wsel.cmp_lo),
    .wr_hi    (wsel.cmp_hi),
    .wr_rel   (wsel.rel),
    .wdata    (bus_wdata),
    .cmp      (cmp),
    .rel_view (rel_view),
    .reached  (reached)
  );

  tct_autoinc u_ai (
    .clk     (clk),
    .rst     (rst),
    .count   (count),
    .wr_ctl  (wsel.aictl),
    .wr_step (wsel.step),
    .wdata   (bus_wdata),
    .mode_on (mode_on),
    .pending (pending),
    .point   (point),
    .step    (step)
  );

  // the auto-increment mode owns the flag while it is on
  assign status = en_q && (mode_on ? pending : reached);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
      freq_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      if (wsel.ctrl) begin
        en_q   <= bus_wdata[0];
        mask_q <= bus_wdata[1];
      end
      if (wsel.freq) freq_q <= bus_wdata;
      irq_out <= status && !mask_q;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_CNT_LO): rd_mux = count[WORD_W-1:0];
      ADDR_W'(OFS_CNT_HI): rd_mux = count[CNT_W-1:WORD_W];
      ADDR_W'(OFS_FREQ):   rd_mux = freq_q;
      ADDR_W'(OFS_CMP_LO): rd_mux = cmp[WORD_W-1:0];
      ADDR_W'(OFS_CMP_HI): rd_mux = cmp[CNT_W-1:WORD_W];
      ADDR_W'(OFS_REL):    rd_mux = rel_view;
      ADDR_W'(OFS_CTRL):   rd_mux = {29'b0, status, mask_q, en_q};
      ADDR_W'(OFS_AIP_LO): rd_mux = point[WORD_W-1:0];
      ADDR_W'(OFS_AIP_HI): rd_mux = point[CNT_W-1:WORD_W];
      ADDR_W'(OFS_STEP):   rd_mux = step;
      ADDR_W'(OFS_AICTL):  rd_mux = {30'b0, pending, mode_on};
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9: a masked or disabled timer raises no interrupt next cycle
  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_out);
  assert_irq_en_R9: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_out);
  // R3: the flag never shows with the timer off
  assert_status_off_R3: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !status);
  // R12: read data holds between reads
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R10: frequency only changes on its own write
  assert_freq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wsel.freq |=> $stable(freq_q));
endmodule

// File: tb/tct_timer_bench.sv
`timescale 1ns/1ps
module tct_timer_bench;
  localparam logic [63:0] HI_RESET = 64'h0000_0041_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b, rdata;
  logic        irq_a, irq_b;

  int tests = 0;
  int fails = 0;

  // bench model of the default instance
  logic [63:0] m_cnt, m_cmp, m_pt;
  logic [31:0] m_step, m_freq;
  logic        m_en, m_mask, m_ai, m_pend;

  always #2.5 clk = ~clk;

  tct_timer u_tct_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_wr(wr && !sel), .bus_rd(rd && !sel),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_out(irq_a));

  tct_timer #(.CNT_RESET(HI_RESET)) u_tct_timer_hi (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_wr(wr && sel), .bus_rd(rd && sel),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_out(irq_b));

  assign rdata = sel ? rdata_b : rdata_a;

  function automatic logic exp_status();
    return m_en && (m_ai ? m_pend : (m_cnt >= m_cmp));
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {29'b0, exp_status(), m_mask, m_en};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!sel) begin
      case (a)
        8'h10: m_freq = d;
        8'h20: m_cmp[31:0] = d;
        8'h24: m_cmp[63:32] = d;
        8'h28: m_cmp = m_cnt + {{32{d[31]}}, d};
        8'h2C: begin m_en = d[0]; m_mask = d[1]; end
        8'h48: m_step = d;
        8'h4C: begin
          if (d[0] && !m_ai) begin m_pt = m_cnt + {32'b0, m_step}; m_pend = 1'b0; end
          else if (!d[1]) m_pend = 1'b0;
          m_ai = d[0];
        end
        default: ;
      endcase
    end
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic step_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      if (!sel && m_en) begin
        m_cnt = m_cnt + 64'd1;
        if (m_ai && m_cnt >= m_pt) begin m_pend = 1'b1; m_pt = m_pt + {32'b0, m_step}; end
      end
    end
    tick_in = 1'b0;
    idle(2);
  endtask

  task automatic check_model(input string tag);
    logic [31:0] v;
    logic [63:0] diff;
    diff = m_cmp - m_cnt;
    rreg(8'h2C, v); chk({tag, " R3 ctrl"}, v, exp_ctrl());
    rreg(8'h28, v); chk({tag, " R4 rel view"}, v, diff[31:0]);
    rreg(8'h00, v); chk({tag, " R2 count lo"}, v, m_cnt[31:0]);
    rreg(8'h4C, v); chk({tag, " R8 aictl"}, v, {30'b0, m_pend, m_ai});
    if (m_ai) begin rreg(8'h40, v); chk({tag, " R7 point lo"}, v, m_pt[31:0]); end
    idle(1);
    chk({tag, " R9 irq"}, irq_a, exp_status() && !m_mask);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_cnt = '0; m_cmp = '0; m_pt = '0; m_step = '0; m_freq = '0;
    m_en = 0; m_mask = 0; m_ai = 0; m_pend = 0;
    void'($urandom(32'd4711));
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rreg(8'h2C, v); chk("R1 ctrl", v, 0);
    rreg(8'h00, v); chk("R1 count lo", v, 0);
    rreg(8'h04, v); chk("R1 count hi", v, 0);
    rreg(8'h28, v); chk("R1 rel view", v, 0);
    chk("R1 irq", irq_a, 0);

    // R2 ticks with the timer off do nothing
    step_ticks(20);
    rreg(8'h00, v); chk("R2 disabled hold", v, 0);

    // basic compare sequence
    wreg(8'h2C, 32'd1);
    step_ticks(100);
    rreg(8'h00, v); chk("R2 count 100", v, 100);
    wreg(8'h20, 32'd4000); wreg(8'h24, 32'd0);
    rreg(8'h28, v); chk("R4 rel 3900", v, 3900);
    rreg(8'h2C, v); chk("R5 not reached", v, 1);
    step_ticks(3900);
    rreg(8'h28, v); chk("R4 rel zero", v, 0);
    rreg(8'h2C, v); chk("R3 ctrl reads 5", v, 5);
    chk("R9 irq set", irq_a, 1);

    // R10 frequency readback, no effect
    wreg(8'h10, 32'h01E8_4800);
    rreg(8'h10, v); chk("R10 freq readback", v, 32'h01E8_4800);
    rreg(8'h2C, v); chk("R10 ctrl unchanged", v, 5);

    // auto-increment
    wreg(8'h48, 32'd200);
    wreg(8'h4C, 32'd1);
    rreg(8'h40, v); chk("R6 point 4200", v, 4200);
    rreg(8'h44, v); chk("R6 point hi", v, 0);
    rreg(8'h2C, v); chk("R6 flag clear", v, 1);
    step_ticks(100);
    rreg(8'h2C, v); chk("R7 before match", v, 1);
    step_ticks(100);
    rreg(8'h2C, v); chk("R7 at match", v, 5);
    rreg(8'h40, v); chk("R7 point 4400", v, 4400);
    step_ticks(100);
    wreg(8'h4C, 32'd3);
    rreg(8'h2C, v); chk("R8 keep pending", v, 5);
    rreg(8'h40, v); chk("R6 no reload when on", v, 4400);
    wreg(8'h4C, 32'd1);
    rreg(8'h2C, v); chk("R8 clear pending", v, 1);
    step_ticks(100);
    rreg(8'h2C, v); chk("R8 fires again", v, 5);
    rreg(8'h40, v); chk("R7 point 4600", v, 4600);

    // R3 mask and read-only flag; R9 masked irq
    wreg(8'h2C, 32'd3);
    idle(1);
    chk("R9 masked irq", irq_a, 0);
    rreg(8'h2C, v); chk("R3 mask readback", v, 7);
    wreg(8'h2C, 32'd4);
    rreg(8'h2C, v); chk("R3 status read-only", v, 0);
    wreg(8'h2C, 32'd1);

    // R4 negative relative write, R5 reached by it
    wreg(8'h4C, 32'd0);
    wreg(8'h28, 32'hFFFF_FFCE);
    rreg(8'h28, v); chk("R4 negative rel", v, 32'hFFFF_FFCE);
    rreg(8'h2C, v); chk("R5 reached via rel", v, 5);
    rreg(8'h24, v); chk("R4 cmp hi", v, 0);

    // R12 unmapped offset and hold
    rreg(8'h08, v); chk("R12 unmapped", v, 0);
    idle(3);
    chk("R12 rdata holds", rdata, 0);

    // random phase against the model
    for (int it = 0; it < 150; it++) begin
      int k;
      k = $urandom % 8;
      case (k)
        0: step_ticks($urandom % 200);
        1: begin
             wreg(8'h20, m_cnt[31:0] + ($urandom % 400));
             wreg(8'h24, m_cnt[63:32]);
           end
        2: wreg(8'h28, 32'($signed($urandom % 600) - 300));
        3: wreg(8'h2C, $urandom % 8);
        4: wreg(8'h48, ($urandom % 300) + 1);
        5: wreg(8'h4C, $urandom % 4);
        6: wreg(8'h10, $urandom);
        default: begin rreg(8'h10, v); chk("R10 rand freq", v, m_freq); end
      endcase
      idle(1);
      check_model("rand");
    end

    // R11 carries on the second instance
    sel = 1'b1;
    wreg(8'h2C, 32'd1);
    wreg(8'h48, 32'h200);
    wreg(8'h4C, 32'd1);
    rreg(8'h40, v); chk("R11 point lo", v, 32'h100);
    rreg(8'h44, v); chk("R11 point hi", v, 32'h42);
    step_ticks(32'h180);
    rreg(8'h00, v); chk("R11 count lo", v, 32'h80);
    rreg(8'h04, v); chk("R11 count hi", v, 32'h42);
    step_ticks(32'h80);
    rreg(8'h2C, v); chk("R11 match after carry", v, 5);
    rreg(8'h40, v); chk("R11 point advanced", v, 32'h300);
    sel = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule